// File: doc/BRIEF.md
# Modified-Immediate Constant Expander

This block turns the encoded immediate field of an instruction word into the 32-bit constant it stands for, together with the carry-out that the immediate form of a logical operation would produce. One mode input picks the encoding. In rotated-byte mode the low twelve bits of the word hold an 8-bit value and a 4-bit rotate count, and the byte is rotated right by twice that count. In compact mode a 12-bit field is gathered from three scattered places in the word. The field either repeats its low byte across the word in one of four patterns, or forms an 8-bit value with an implied leading one that is rotated right by a 5-bit amount.

Alongside the constant, the block gives the gathered 12-bit field zero-extended to a word, two offsets scaled by four (from a 7-bit and from an 8-bit slice of the word), and a flag that marks a 4-bit register number that many register specifiers may not use. All outputs are registered. A result appears one clock after its inputs are sampled, so a decode stage can place the unit on a pipeline boundary.

Top module: `imm_expand_unit`

## Requirements
- R1: Every output is registered. The values seen after rising edge k are a pure function of the inputs sampled at edge k. While rst_n is low, all outputs read zero.
- R2: With mode = 0 (rotated-byte), imm_value is opword[7:0] zero-extended and rotated right by 2 * opword[11:8].
- R3: With mode = 0, carry_out equals carry_in when opword[11:8] is zero. Otherwise carry_out equals bit 31 of imm_value.
- R4: The compact field f[11:0] is {opword[26], opword[14:12], opword[7:0]}, with opword[26] as the MSB. imm12_zx is f zero-extended to 32 bits in both modes.
- R5: With mode = 1 and f[11:10] = 0, let b = f[7:0]. f[9:8] selects the result: 0 gives 0x000000bb, 1 gives 0x00bb00bb, 2 gives 0xbb00bb00, 3 gives 0xbbbbbbbb. carry_out equals carry_in, and b = 0 gives zero.
- R6: With mode = 1 and f[11:10] nonzero, imm_value is {1, f[6:0]} zero-extended and rotated right by f[11:7], an amount from 8 to 31. carry_out equals bit 31 of imm_value.
- R7: off7_x4 is opword[6:0] * 4 and off8_x4 is opword[7:0] * 4, both zero-extended to 32 bits.
- R8: reg_forbidden is 1 exactly when reg_num is 13 or 15.
- R9: The mode input selects the scheme: 0 selects rotated-byte, 1 selects compact. Bits of opword outside the chosen scheme's field have no effect on imm_value or carry_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 = rotated-byte scheme, 1 = compact scheme |
| opword | input | 32 | Instruction word that holds the immediate fields |
| carry_in | input | 1 | Current carry flag |
| reg_num | input | 4 | Register number to screen |
| imm_value | output | 32 | Expanded constant |
| carry_out | output | 1 | Carry produced by the expansion |
| imm12_zx | output | 32 | Gathered 12-bit field, zero-extended |
| off7_x4 | output | 32 | opword[6:0] scaled by four |
| off8_x4 | output | 32 | opword[7:0] scaled by four |
| reg_forbidden | output | 1 | reg_num is 13 or 15 |

## Verification
The assertions assume that the inputs are known and two-valued at every clock edge once reset is released. They also assume that each result is judged against the inputs of the edge just before it. The stable-output property also assumes that the same input word, seen on two edges in a row, must give the same result. The bench drives every input at the falling edge, keeps it fixed through the next rising edge, and fills the opword bits outside each scheme's field with random values. This lets the checks show that only the documented bit positions reach the constant. The sweep covers all 4096 field values in each mode with both carry values, and a tally confirms that every compact rotation from 8 to 31 was exercised.

// File: rtl/imx_pkg.sv
package imx_pkg;

    localparam int IMX_WORD_W  = 32;
    localparam int IMX_FIELD_W = 12;
    localparam int IMX_BYTE_W  = 8;
    localparam int IMX_LANES   = IMX_WORD_W / IMX_BYTE_W;
    localparam int IMX_ROT_W   = $clog2(IMX_WORD_W);
    localparam int IMX_REG_W   = 4;

    typedef enum logic {
        IMX_MODE_ROTBYTE = 1'b0,
        IMX_MODE_COMPACT = 1'b1
    } imx_mode_e;

    typedef struct packed {
        logic [IMX_WORD_W-1:0] value;
        logic                  carry;
        logic [IMX_WORD_W-1:0] imm12_zx;
        logic [IMX_WORD_W-1:0] off7;
        logic [IMX_WORD_W-1:0] off8;
        logic                  forbidden;
    } imx_result_t;

    // rotate right through a doubled word, so an amount of zero returns v
    function automatic logic [IMX_WORD_W-1:0] imx_ror(
        input logic [IMX_WORD_W-1:0] v,
        input logic [IMX_ROT_W-1:0]  n
    );
        logic [2*IMX_WORD_W-1:0] dbl;
        dbl = {v, v} >> n;
        return dbl[IMX_WORD_W-1:0];
    endfunction

endpackage

// File: rtl/imx_rotbyte_path.sv
module imx_rotbyte_path
    import imx_pkg::*;
(
    input  logic [IMX_FIELD_W-1:0] field,
    input  logic                   carry_in,
    output logic [IMX_WORD_W-1:0]  value,
    output logic                   carry_out
);
    localparam int CNT_W = IMX_FIELD_W - IMX_BYTE_W;

    logic [CNT_W-1:0]     rot_cnt;
    logic [IMX_ROT_W-1:0] rot_amt;

    assign rot_cnt = field[IMX_FIELD_W-1:IMX_BYTE_W];
    // the amount is always even: count shifted left by one
    assign rot_amt = {rot_cnt, 1'b0};

    always_comb begin
        value     = imx_ror({{(IMX_WORD_W-IMX_BYTE_W){1'b0}}, field[IMX_BYTE_W-1:0]}, rot_amt);
        carry_out = (rot_cnt == '0) ? carry_in : value[IMX_WORD_W-1];
    end

endmodule

// File: rtl/imx_compact_path.sv
module imx_compact_path
    import imx_pkg::*;
(
    input  logic                  op_hi,
    input  logic [2:0]            op_mid,
    input  logic [IMX_BYTE_W-1:0] op_lo,
    input  logic                  carry_in,
    output logic [IMX_FIELD_W-1:0] field,
    output logic [IMX_WORD_W-1:0] value,
    output logic                  carry_out
);
    logic [IMX_WORD_W-1:0] rep_value;
    logic [IMX_WORD_W-1:0] rot_value;
    logic [IMX_LANES-1:0]  lane_en;
    logic                  use_rep;

    assign field   = {op_hi, op_mid, op_lo};
    assign use_rep = (field[11:10] == 2'b00);

    // lane enables per replication selector
    always_comb begin
        unique case (field[9:8])
            2'd0:    lane_en = 4'b0001;
            2'd1:    lane_en = 4'b0101;
            2'd2:    lane_en = 4'b1010;
            default: lane_en = 4'b1111;
        endcase
    end

    for (genvar g = 0; g < IMX_LANES; g++) begin : g_lane
        assign rep_value[g*IMX_BYTE_W +: IMX_BYTE_W] =
            lane_en[g] ? field[IMX_BYTE_W-1:0] : '0;
    end

    // implied leading one above seven payload bits
    assign rot_value = imx_ror({{(IMX_WORD_W-IMX_BYTE_W){1'b0}}, 1'b1, field[6:0]},
                               field[11:7]);

    always_comb begin
        if (use_rep) begin
            value     = rep_value;
            carry_out = carry_in;
        end else begin
            value     = rot_value;
            carry_out = rot_value[IMX_WORD_W-1];
        end
    end

endmodule

// File: rtl/imx_side_fields.sv
module imx_side_fields
    import imx_pkg::*;
(
    input  logic [IMX_FIELD_W-1:0] field,
    input  logic [IMX_BYTE_W-1:0]  op_lo,
    input  logic [IMX_REG_W-1:0]   reg_num,
    output logic [IMX_WORD_W-1:0]  imm12_zx,
    output logic [IMX_WORD_W-1:0]  off7_x4,
    output logic [IMX_WORD_W-1:0]  off8_x4,
    output logic                   forbidden
);
    assign imm12_zx  = {{(IMX_WORD_W-IMX_FIELD_W){1'b0}}, field};
    assign off7_x4   = {{(IMX_WORD_W-9){1'b0}}, op_lo[6:0], 2'b00};
    assign off8_x4   = {{(IMX_WORD_W-10){1'b0}}, op_lo, 2'b00};
    assign forbidden = (reg_num == 4'd13) || (reg_num == 4'd15);
endmodule

// File: rtl/imm_expand_unit.sv
module imm_expand_unit
    import imx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode,
    input  logic [IMX_WORD_W-1:0] opword,
    input  logic                  carry_in,
    input  logic [IMX_REG_W-1:0]  reg_num,
    output logic [IMX_WORD_W-1:0] imm_value,
    output logic                  carry_out,
    output logic [IMX_WORD_W-1:0] imm12_zx,
    output logic [IMX_WORD_W-1:0] off7_x4,
    output logic [IMX_WORD_W-1:0] off8_x4,
    output logic                  reg_forbidden
);
    imx_mode_e             mode_sel;
    logic [IMX_WORD_W-1:0] rb_value;
    logic                  rb_carry;
    logic [IMX_WORD_W-1:0] cp_value;
    logic                  cp_carry;
    logic [IMX_FIELD_W-1:0] cp_field;
    logic [IMX_WORD_W-1:0] sd_imm12;
    logic [IMX_WORD_W-1:0] sd_off7;
    logic [IMX_WORD_W-1:0] sd_off8;
    logic                  sd_forbid;
    imx_result_t           res_d;
    imx_result_t           res_q;

    assign mode_sel = imx_mode_e'(mode);

    imx_rotbyte_path u_rotbyte (
        .field     (opword[IMX_FIELD_W-1:0]),
        .carry_in  (carry_in),
        .value     (rb_value),
        .carry_out (rb_carry)
    );

    imx_compact_path u_compact (
        .op_hi     (opword[26]),
        .op_mid    (opword[14:12]),
        .op_lo     (opword[7:0]),
        .carry_in  (carry_in),
        .field     (cp_field),
        .value     (cp_value),
        .carry_out (cp_carry)
    );

    imx_side_fields u_side (
        .field     (cp_field),
        .op_lo     (opword[7:0]),
        .reg_num   (reg_num),
        .imm12_zx  (sd_imm12),
        .off7_x4   (sd_off7),
        .off8_x4   (sd_off8),
        .forbidden (sd_forbid)
    );

    always_comb begin
        res_d = '0;
        if (mode_sel == IMX_MODE_COMPACT) begin
            res_d.value = cp_value;
            res_d.carry = cp_carry;
        end else begin
            res_d.value = rb_value;
            res_d.carry = rb_carry;
        end
        res_d.imm12_zx  = sd_imm12;
        res_d.off7      = sd_off7;
        res_d.off8      = sd_off8;
        res_d.forbidden = sd_forbid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign imm_value     = res_q.value;
    assign carry_out     = res_q.carry;
    assign imm12_zx      = res_q.imm12_zx;
    assign off7_x4       = res_q.off7;
    assign off8_x4       = res_q.off8;
    assign reg_forbidden = res_q.forbidden;

    // R1: same inputs on two edges in a row give an unchanged result
    assert_pure_function_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) &&
         $past({mode, opword, carry_in, reg_num}) == $past({mode, opword, carry_in, reg_num}, 2))
        |-> ($stable(imm_value) && $stable(carry_out) && $stable(imm12_zx) &&
             $stable(off7_x4) && $stable(off8_x4) && $stable(reg_forbidden)));

    // R2, R3: zero rotate count passes the byte and the carry straight through
    assert_rot_zero_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode == 1'b0 && opword[11:8] == 4'd0))
        |-> (imm_value == {24'd0, $past(opword[7:0])} && carry_out == $past(carry_in)));

    // R2, R3: a rotation keeps the bit count and carries out the top bit
    assert_rot_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode == 1'b0 && opword[11:8] != 4'd0))
        |-> (carry_out == imm_value[31] &&
             $countones(imm_value) == $countones($past(opword[7:0]))));

    // R5: full replication puts four copies of the byte in the word, carry passes
    assert_rep_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode == 1'b1 && opword[26] == 1'b0 && opword[14:12] == 3'b011))
        |-> ($countones(imm_value) == 4 * $countones($past(opword[7:0])) &&
             carry_out == $past(carry_in)));

    // R6: rotated form has one more set bit than its payload and carries out bit 31
    assert_cmp_rot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode == 1'b1 && (opword[26] || opword[14])))
        |-> (carry_out == imm_value[31] &&
             $countones(imm_value) == 1 + $countones($past(opword[6:0]))));

    // R8: flag only for numbers with bits 0, 2 and 3 all set
    assert_reg_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (reg_forbidden == $past(reg_num[3] & reg_num[2] & reg_num[0])));

endmodule

// File: tb/imm_expand_unit_test.sv
`timescale 1ns/1ps
module imm_expand_unit_test;

    typedef struct {
        logic [31:0] value;
        logic        carry;
        logic [31:0] imm12;
        logic [31:0] off7;
        logic [31:0] off8;
        logic        forbid;
        string       vtag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode = 1'b0;
    logic [31:0] opword = '0;
    logic        carry_in = 1'b0;
    logic [3:0]  reg_num = '0;
    logic [31:0] imm_value;
    logic        carry_out;
    logic [31:0] imm12_zx;
    logic [31:0] off7_x4;
    logic [31:0] off8_x4;
    logic        reg_forbidden;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    bit   [31:0] rot_seen = '0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    imm_expand_unit uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .opword(opword),
        .carry_in(carry_in), .reg_num(reg_num), .imm_value(imm_value),
        .carry_out(carry_out), .imm12_zx(imm12_zx), .off7_x4(off7_x4),
        .off8_x4(off8_x4), .reg_forbidden(reg_forbidden)
    );

    function automatic logic [31:0] ref_ror(logic [31:0] v, int n);
        for (int i = 0; i < n; i++) v = {v[0], v[31:1]};
        return v;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_item(logic m, logic [11:0] f, logic cin, logic [3:0] rn);
        exp_t e;
        logic [31:0] op;
        logic [7:0]  b;
        op = $urandom;
        if (m) begin
            op[26] = f[11]; op[14:12] = f[10:8]; op[7:0] = f[7:0];
        end else begin
            op[11:0] = f;
        end
        b = f[7:0];
        if (!m) begin
            e.vtag  = "R2 R3 R9 rotated-byte";
            e.value = ref_ror({24'd0, b}, 2 * f[11:8]);
            e.carry = (f[11:8] == 0) ? cin : e.value[31];
        end else if (f[11:10] == 2'b00) begin
            e.vtag = "R5 R9 replicate";
            case (f[9:8])
                2'd0: e.value = {24'd0, b};
                2'd1: e.value = {8'd0, b, 8'd0, b};
                2'd2: e.value = {b, 8'd0, b, 8'd0};
                default: e.value = {b, b, b, b};
            endcase
            e.carry = cin;
        end else begin
            e.vtag  = "R6 R9 compact-rotate";
            e.value = ref_ror({24'd0, 1'b1, f[6:0]}, f[11:7]);
            e.carry = e.value[31];
            rot_seen[f[11:7]] = 1'b1;
        end
        e.imm12  = {20'd0, op[26], op[14:12], op[7:0]};
        e.off7   = {23'd0, op[6:0], 2'b00};
        e.off8   = {22'd0, op[7:0], 2'b00};
        e.forbid = (rn == 4'd13) || (rn == 4'd15);
        @(negedge clk);
        mode = m; opword = op; carry_in = cin; reg_num = rn;
        sb.push_back(e);
    endtask

    // monitor: each result leaves the register one edge after its inputs
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check({"value ", e.vtag}, imm_value, e.value);
                check({"carry ", e.vtag}, {31'd0, carry_out}, {31'd0, e.carry});
                check("R4 imm12_zx", imm12_zx, e.imm12);
                check("R7 off7_x4", off7_x4, e.off7);
                check("R7 off8_x4", off8_x4, e.off8);
                check("R8 reg_forbidden", {31'd0, reg_forbidden}, {31'd0, e.forbid});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired before the sweep ended");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state with busy inputs
        mode = 1'b1; opword = 32'hFFFF_FFFF; carry_in = 1'b1; reg_num = 4'd15;
        repeat (4) @(negedge clk);
        check("R1 reset imm_value", imm_value, 32'd0);
        check("R1 reset carry_out", {31'd0, carry_out}, 32'd0);
        check("R1 reset imm12_zx", imm12_zx, 32'd0);
        check("R1 reset offsets", off7_x4 | off8_x4, 32'd0);
        check("R1 reset reg_forbidden", {31'd0, reg_forbidden}, 32'd0);
        rst_n = 1'b1;

        // R5: zero byte in every replication pattern, both carries
        for (int s = 0; s < 4; s++)
            for (int c = 0; c < 2; c++)
                drive_item(1'b1, {2'b00, 2'(s), 8'h00}, 1'(c), 4'(s));

        // full sweep: both modes, all fields, both carry values
        for (int m = 0; m < 2; m++)
            for (int c = 0; c < 2; c++)
                for (int f = 0; f < 4096; f++)
                    drive_item(1'(m), 12'(f), 1'(c), 4'(f));

        @(negedge clk);
        @(negedge clk);
        // R6: every compact rotation amount 8..31 was exercised
        check("R6 rotation coverage 8..31", {rot_seen[31:8], 8'd0}, 32'hFFFF_FF00);
        check("R1 scoreboard drained", sb.size(), 32'd0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule